// File: doc/BRIEF.md
# Two-Core Interrupt Router

This block collects interrupt requests for a system with two processor cores and decides, for each core, whether an interrupt line should be raised. There are three kinds of source. Software requests are raised by a bus write. Each core has its own private peripheral lines. Shared peripheral lines are common to the whole system. Every interrupt ID has an enable bit and a pending bit. An interrupt reaches a core only when it is pending, enabled and aimed at that core. Each core receives a normal interrupt line, a fast interrupt line and the number of its lowest-numbered qualifying interrupt.

A simple word-addressed register bus carries the number of the requesting core on every access. State for IDs 0 to 31 exists once per core, so the same address reaches a different copy depending on which core issues the access. State for IDs 32 to 63 is held once and shared by both cores. A per-ID target mask steers each shared interrupt to any subset of the cores. Each core also has a bypass normal line and a bypass fast line. These skip every gate in the block and go straight to that core's outputs.

Top module: `irq_router`

## Requirements
- R1: After a synchronous reset, every ID is disabled and not pending, all target masks are zero, every readable register returns 0, `hp_id` is 1023 for both cores and the registered interrupt outputs are low.
- R2: IDs 0-15 are software requests. IDs 16-31 are private: `local_src[c*16+k]` is a level source for ID 16+k in core c's copy only. IDs 32-63 are shared: `shared_src[k]` is a level source for ID 32+k. A level source that is high sets its pending bit on every clock edge.
- R3: Word addresses are as follows. Enable-set is 0 (IDs 0-31) and 1 (IDs 32-63). Enable-clear is 2 and 3. Pending-set is 4 and 5. Pending-clear is 6 and 7. In each case bit i covers ID i or ID 32+i, a 1 sets or clears that bit, and a 0 leaves it unchanged. A read of 0 or 2 (1 or 3) returns the enable word, and a read of 4 or 6 (5 or 7) returns the pending word. Read data appears in `bus_rdata` one cycle after `bus_rd`.
- R4: Addresses 0, 2, 4, 6 and 8 act only on the copy that belongs to `bus_core`. An access by one core never changes, and never shows, the other core's copy.
- R5: Enable and pending state for IDs 32-63 is global. A clear by either core blocks that ID on every core, and both cores read the same value.
- R6: Addresses 10 and 11 are the shared target masks. ID 32+k uses word 10+k/16, bits [2*(k%16)+1 : 2*(k%16)], and bit 0 of that field stands for core 0. A shared ID reaches only the cores set in its mask. Private IDs ignore the masks.
- R7: A write to address 12 raises a software request. Bits [3:0] give the ID. Bit 15 set means all cores; otherwise bits [17:16] give the core mask. Pending is set only in the selected cores' copies.
- R8: A core's `irq_o` or `fast_o` rises when some ID is pending, enabled and aimed at that core. The outputs are registered, so they follow the state one clock later.
- R9: Addresses 8 (IDs 0-31, per core) and 9 (IDs 32-63, global) are plain read/write words. A 1 in bit i routes that ID to `fast_o` instead of `irq_o`.
- R10: `hp_id[c*10 +: 10]` gives the lowest-numbered ID that is pending, enabled and aimed at core c, or 1023 when there is none.
- R11: A read of address 13 returns that ID for `bus_core` (or 1023) and clears its pending bit, in the core's own copy or in the global copy. If the level source is still high, the bit stays pending.
- R12: `bypass_irq[c]` and `bypass_fast[c]` are ORed into `irq_o[c]` and `fast_o[c]` without passing through any register or gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_core | input | 1 | Number of the requesting core |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| local_src | input | 32 | Private level sources, 16 per core |
| shared_src | input | 32 | Shared level sources for IDs 32-63 |
| bypass_irq | input | 2 | Bypass normal line per core |
| bypass_fast | input | 2 | Bypass fast line per core |
| irq_o | output | 2 | Normal interrupt line per core |
| fast_o | output | 2 | Fast interrupt line per core |
| hp_id | output | 20 | Lowest qualifying ID per core, 10 bits each |

## Verification
The bench focuses on the cases where the two cores must see different results.

- **Banking.** It writes enable and pending bits from one core and reads them from both. If the banking were lost, the second core would see the first core's bits.
- **Private lines.** It drives a private line of core 1 while core 0 has the same ID enabled. A router that treated private IDs as shared would wake core 0.
- **Shared interrupts.** It steers a shared ID with its target mask and then clears its enable from the other core. A per-core shared enable would leave one core still interrupted.
- **Software requests.** It sends a software request to one core and then to all cores. A decode that ignored the mask would wake both cores at once.
- **Fast routing.** It sets fast routing in a single core's copy. A global fast bit would move the other core's request off its normal line.
- **Acknowledge.** It acknowledges a run of pending IDs to check lowest-first ordering and the final 1023. It also acknowledges while a level source is still high, which must leave the ID pending.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int HPW = 10;
  localparam logic [HPW-1:0] NO_IRQ = 10'd1023;

  typedef enum logic [3:0] {
    A_ENS_LO = 4'd0,  A_ENS_HI = 4'd1,
    A_ENC_LO = 4'd2,  A_ENC_HI = 4'd3,
    A_PDS_LO = 4'd4,  A_PDS_HI = 4'd5,
    A_PDC_LO = 4'd6,  A_PDC_HI = 4'd7,
    A_FST_LO = 4'd8,  A_FST_HI = 4'd9,
    A_TGT0   = 4'd10, A_TGT1   = 4'd11,
    A_SOFT   = 4'd12, A_ACK    = 4'd13
  } reg_addr_e;
endpackage

// File: rtl/irq_bank.sv
module irq_bank
  import irq_router_pkg::*;
#(
  parameter int NSOFT = 16,
  parameter int NLOC  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [3:0]            addr,
  input  logic [31:0]           wdata,
  input  logic [NLOC-1:0]       loc_lvl,
  input  logic [NSOFT-1:0]      soft_set,
  input  logic [NSOFT+NLOC-1:0] ack_clr,
  output logic [NSOFT+NLOC-1:0] en_o,
  output logic [NSOFT+NLOC-1:0] pend_o,
  output logic [NSOFT+NLOC-1:0] fast_o
);
  localparam int W = NSOFT + NLOC;

  logic [W-1:0] en_q, pend_q, fast_q;
  logic [W-1:0] set_v, clr_v, lvl_v;

  always_comb begin
    set_v = (wr_en && addr == A_PDS_LO) ? wdata[W-1:0] : '0;
    clr_v = ((wr_en && addr == A_PDC_LO) ? wdata[W-1:0] : '0) | ack_clr;
    lvl_v = {loc_lvl, soft_set};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
      fast_q <= '0;
    end else begin
      if (wr_en && addr == A_ENS_LO)      en_q <= en_q | wdata[W-1:0];
      else if (wr_en && addr == A_ENC_LO) en_q <= en_q & ~wdata[W-1:0];
      if (wr_en && addr == A_FST_LO)      fast_q <= wdata[W-1:0];
      pend_q <= (pend_q & ~clr_v) | set_v | lvl_v;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign fast_o = fast_q;

  // R3
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (|clr_v) |=> ((pend_q & $past(clr_v & ~set_v & ~lvl_v)) == '0));
endmodule

// File: rtl/irq_shared.sv
module irq_shared
  import irq_router_pkg::*;
#(
  parameter int NSH = 32,
  parameter int NC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [3:0]       addr,
  input  logic [31:0]      wdata,
  input  logic [NSH-1:0]   src,
  input  logic [NSH-1:0]   ack_clr,
  output logic [NSH-1:0]   en_o,
  output logic [NSH-1:0]   pend_o,
  output logic [NSH-1:0]   fast_o,
  output logic [NSH*NC-1:0] tgt_o
);
  localparam int TPW = 32 / NC;
  localparam int NTW = NSH / TPW;

  logic [NSH-1:0]    en_q, pend_q, fast_q;
  logic [NSH*NC-1:0] tgt_q;
  logic [NSH-1:0]    set_v, clr_v;

  always_comb begin
    set_v = (wr_en && addr == A_PDS_HI) ? wdata[NSH-1:0] : '0;
    clr_v = ((wr_en && addr == A_PDC_HI) ? wdata[NSH-1:0] : '0) | ack_clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
      fast_q <= '0;
      tgt_q  <= '0;
    end else begin
      if (wr_en && addr == A_ENS_HI)      en_q <= en_q | wdata[NSH-1:0];
      else if (wr_en && addr == A_ENC_HI) en_q <= en_q & ~wdata[NSH-1:0];
      if (wr_en && addr == A_FST_HI)      fast_q <= wdata[NSH-1:0];
      for (int k = 0; k < NTW; k++)
        if (wr_en && addr == 4'(A_TGT0) + 4'(k))
          tgt_q[k*TPW*NC +: TPW*NC] <= wdata[TPW*NC-1:0];
      pend_q <= (pend_q & ~clr_v) | set_v | src;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign fast_o = fast_q;
  assign tgt_o  = tgt_q;

  // R5
  shr_disable_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_ENC_HI) |=> ((en_q & $past(wdata[NSH-1:0])) == '0));
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  qual,
  input  logic [N-1:0]  fastv,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic          any_norm,
  output logic          any_fast
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (qual[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
    any_norm = |(qual & ~fastv);
    any_fast = |(qual & fastv);
  end

  // R10
  always_comb begin
    pick_valid_chk: assert (!found || qual[idx]);
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NC  = 2,
  parameter int NSH = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [3:0]            bus_addr,
  input  logic [31:0]           bus_wdata,
  input  logic [(NC>1 ? $clog2(NC) : 1)-1:0] bus_core,
  output logic [31:0]           bus_rdata,
  input  logic [NC*16-1:0]      local_src,
  input  logic [NSH-1:0]        shared_src,
  input  logic [NC-1:0]         bypass_irq,
  input  logic [NC-1:0]         bypass_fast,
  output logic [NC-1:0]         irq_o,
  output logic [NC-1:0]         fast_o,
  output logic [NC*HPW-1:0]     hp_id
);
  localparam int NSOFT = 16;
  localparam int NLOC  = 16;
  localparam int NB    = NSOFT + NLOC;
  localparam int NID   = NB + NSH;
  localparam int IW    = $clog2(NID);
  localparam int CW    = NC > 1 ? $clog2(NC) : 1;

  logic [NB-1:0]     en_b [NC];
  logic [NB-1:0]     pend_b [NC];
  logic [NB-1:0]     fast_b [NC];
  logic [NB-1:0]     ack_b [NC];
  logic [NSH-1:0]    en_g, pend_g, fast_g, ack_g;
  logic [NSH*NC-1:0] tgt_g;
  logic [NC-1:0]     fnd, nrm, fst;
  logic [IW-1:0]     idx [NC];
  logic [HPW-1:0]    hp_c [NC];
  logic [HPW-1:0]    hp_q [NC];
  logic [NC-1:0]     irq_q, fast_q;

  logic              soft_we, ack_rd;
  logic [NC-1:0]     soft_mask;
  logic [NSOFT-1:0]  soft_vec;

  always_comb begin
    soft_we   = bus_wr && bus_addr == A_SOFT;
    ack_rd    = bus_rd && bus_addr == A_ACK;
    soft_mask = bus_wdata[15] ? '1 : bus_wdata[16 +: NC];
    soft_vec  = NSOFT'(1) << bus_wdata[3:0];
  end

  irq_shared #(.NSH(NSH), .NC(NC)) u_shared (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .src(shared_src), .ack_clr(ack_g),
    .en_o(en_g), .pend_o(pend_g), .fast_o(fast_g), .tgt_o(tgt_g)
  );

  for (genvar c = 0; c < NC; c++) begin : g_core
    logic [NSH-1:0] tcol;
    logic [NID-1:0] qual;

    irq_bank #(.NSOFT(NSOFT), .NLOC(NLOC)) u_bank (
      .clk(clk), .rst(rst), .wr_en(bus_wr && bus_core == CW'(c)),
      .addr(bus_addr), .wdata(bus_wdata),
      .loc_lvl(local_src[c*NLOC +: NLOC]),
      .soft_set((soft_we && soft_mask[c]) ? soft_vec : '0),
      .ack_clr(ack_b[c]),
      .en_o(en_b[c]), .pend_o(pend_b[c]), .fast_o(fast_b[c])
    );

    always_comb begin
      for (int k = 0; k < NSH; k++) tcol[k] = tgt_g[k*NC + c];
      qual = {pend_g & en_g & tcol, pend_b[c] & en_b[c]};
    end

    irq_pick #(.N(NID), .IW(IW)) u_pick (
      .qual(qual), .fastv({fast_g, fast_b[c]}),
      .found(fnd[c]), .idx(idx[c]), .any_norm(nrm[c]), .any_fast(fst[c])
    );

    always_comb begin
      hp_c[c]  = fnd[c] ? HPW'(idx[c]) : NO_IRQ;
      ack_b[c] = (ack_rd && bus_core == CW'(c) && fnd[c] && int'(idx[c]) < NB)
                 ? (NB'(1) << idx[c]) : '0;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        hp_q[c]   <= NO_IRQ;
        irq_q[c]  <= 1'b0;
        fast_q[c] <= 1'b0;
      end else begin
        hp_q[c]   <= hp_c[c];
        irq_q[c]  <= nrm[c];
        fast_q[c] <= fst[c];
      end
    end

    assign hp_id[c*HPW +: HPW] = hp_q[c];

    // R1
    rst_idle_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (hp_q[c] == NO_IRQ && !irq_q[c] && !fast_q[c]));
    // R10
    none_enabled_chk: assert property (@(posedge clk) disable iff (rst)
      (en_b[c] == '0 && en_g == '0) |=> (hp_q[c] == NO_IRQ));
    // R8
    line_up_chk: assert property (@(posedge clk) disable iff (rst)
      (hp_q[c] != NO_IRQ) |-> (irq_q[c] || fast_q[c]));
    // R7
    soft_skip_chk: assert property (@(posedge clk) disable iff (rst)
      (soft_we && !soft_mask[c]) |=> $stable(pend_b[c][NSOFT-1:0]));
  end

  always_comb begin
    ack_g = '0;
    for (int c = 0; c < NC; c++)
      if (ack_rd && bus_core == CW'(c) && fnd[c] && int'(idx[c]) >= NB)
        ack_g = ack_g | (NSH'(1) << (idx[c] - IW'(NB)));
  end

  assign irq_o  = irq_q  | bypass_irq;
  assign fast_o = fast_q | bypass_fast;

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_ENS_LO, A_ENC_LO: bus_rdata <= 32'(en_b[bus_core]);
        A_ENS_HI, A_ENC_HI: bus_rdata <= 32'(en_g);
        A_PDS_LO, A_PDC_LO: bus_rdata <= 32'(pend_b[bus_core]);
        A_PDS_HI, A_PDC_HI: bus_rdata <= 32'(pend_g);
        A_FST_LO:           bus_rdata <= 32'(fast_b[bus_core]);
        A_FST_HI:           bus_rdata <= 32'(fast_g);
        A_TGT0:             bus_rdata <= tgt_g[31:0];
        A_TGT1:             bus_rdata <= tgt_g[63:32];
        A_ACK:              bus_rdata <= 32'(hp_c[bus_core]);
        default:            bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: tb/sim_irq_router.sv
module sim_irq_router;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [0:0]  bus_core;
  logic [31:0] bus_rdata;
  logic [31:0] local_src, shared_src;
  logic [1:0]  bypass_irq, bypass_fast, irq_o, fast_o;
  logic [19:0] hp_id;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_router u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_core(bus_core), .bus_rdata(bus_rdata),
    .local_src(local_src), .shared_src(shared_src), .bypass_irq(bypass_irq),
    .bypass_fast(bypass_fast), .irq_o(irq_o), .fast_o(fast_o), .hp_id(hp_id)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int core, input int addr, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_core = 1'(core); bus_addr = 4'(addr); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int core, input int addr, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_core = 1'(core); bus_addr = 4'(addr);
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] hp(input int c);
    return 32'(hp_id[c*10 +: 10]);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 hp core0", hp(0), 1023);
    chk("R1 hp core1", hp(1), 1023);
    chk("R1 lines", {28'd0, irq_o, fast_o}, 0);
    rd(0, 1, d); chk("R1 shared enable read", d, 0);
  endtask

  task automatic t_bank();
    logic [31:0] d;
    wr(0, 0, 32'h1 << 20);
    rd(0, 0, d); chk("R4 core0 own enable", d, 32'h1 << 20);
    rd(1, 2, d); chk("R4 core1 enable copy untouched", d, 0);
    wr(1, 4, 32'h20);
    rd(1, 6, d); chk("R3 core1 pending set", d, 32'h20);
    rd(0, 4, d); chk("R4 core0 pending copy untouched", d, 0);
    wr(1, 0, 32'h20);
    settle();
    chk("R8 core1 irq", 32'(irq_o), 2);
    chk("R10 core1 hp", hp(1), 5);
    chk("R10 core0 hp", hp(0), 1023);
    wr(1, 6, 32'h20);
    settle();
    chk("R3 clear pending", hp(1), 1023);
    wr(0, 2, 32'h1 << 20);
    rd(0, 0, d); chk("R3 enable clear", d, 0);
  endtask

  task automatic t_local();
    logic [31:0] d;
    wr(0, 0, 32'h1 << 19);
    wr(1, 0, 32'h1 << 19);
    @(negedge clk); local_src[16 + 3] = 1'b1;
    settle();
    chk("R2 private to core1", hp(1), 19);
    chk("R6 private ignores targets core0", hp(0), 1023);
    @(negedge clk); local_src[16 + 3] = 1'b0;
    rd(1, 13, d); chk("R11 ack private", d, 19);
    settle();
    chk("R11 cleared after ack", hp(1), 1023);
    wr(0, 2, 32'h1 << 19);
    wr(1, 2, 32'h1 << 19);
  endtask

  task automatic t_shared();
    logic [31:0] d;
    wr(0, 10, 32'h2 << 16);
    wr(0, 1, 32'h100);
    wr(0, 5, 32'h100);
    settle();
    chk("R6 shared to core1", hp(1), 40);
    chk("R6 shared not core0", hp(0), 1023);
    rd(1, 7, d); chk("R5 global pending view", d, 32'h100);
    wr(1, 3, 32'h100);
    settle();
    chk("R5 global disable", hp(1), 1023);
    wr(0, 10, 32'h3 << 16);
    wr(1, 1, 32'h100);
    settle();
    chk("R6 both targeted core0", hp(0), 40);
    chk("R6 both targeted core1", hp(1), 40);
    wr(0, 7, 32'h100);
    wr(0, 3, 32'h100);
    settle();
    chk("R5 shared cleared", hp(0), 1023);
  endtask

  task automatic t_soft();
    wr(0, 0, 32'h8);
    wr(1, 0, 32'h8);
    wr(0, 12, (32'h1 << 16) | 32'd3);
    settle();
    chk("R7 subset core0", hp(0), 3);
    chk("R7 subset skips core1", hp(1), 1023);
    wr(1, 12, (32'h1 << 15) | 32'd3);
    settle();
    chk("R7 all cores core1", hp(1), 3);
    wr(0, 6, 32'h8);
    wr(1, 6, 32'h8);
    settle();
    chk("R7 cleared", hp(0) | hp(1), 1023);
  endtask

  task automatic t_fast();
    wr(0, 8, 32'h8);
    wr(0, 12, (32'h1 << 15) | 32'd3);
    settle();
    chk("R9 core0 fast", 32'(fast_o), 1);
    chk("R9 core1 normal", 32'(irq_o), 2);
    wr(0, 6, 32'h8);
    wr(1, 6, 32'h8);
    wr(0, 8, 32'h0);
    wr(0, 2, 32'h8);
    wr(1, 2, 32'h8);
    settle();
    chk("R9 idle", {28'd0, irq_o, fast_o}, 0);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    wr(0, 0, 32'h84);
    wr(0, 4, 32'h84);
    settle();
    chk("R10 lowest first", hp(0), 2);
    rd(0, 13, d); chk("R11 ack first", d, 2);
    settle();
    chk("R10 next lowest", hp(0), 7);
    rd(0, 13, d); chk("R11 ack second", d, 7);
    rd(0, 13, d); chk("R11 ack empty", d, 1023);
    wr(0, 2, 32'h84);
    wr(0, 10, 32'h4);
    wr(0, 1, 32'h2);
    @(negedge clk); shared_src[1] = 1'b1;
    settle();
    chk("R2 shared level source", hp(0), 33);
    rd(0, 13, d); chk("R11 ack shared", d, 33);
    rd(0, 5, d); chk("R11 level keeps pending", d, 32'h2);
    @(negedge clk); shared_src[1] = 1'b0;
    rd(0, 13, d); chk("R11 ack again", d, 33);
    rd(0, 5, d); chk("R11 released clears", d, 0);
    wr(0, 3, 32'h2);
  endtask

  task automatic t_bypass();
    settle();
    @(negedge clk); bypass_irq = 2'b10;
    #1 chk("R12 bypass normal", 32'(irq_o), 2);
    bypass_fast = 2'b01;
    #1 chk("R12 bypass fast", 32'(fast_o), 1);
    @(negedge clk); bypass_irq = 2'b00; bypass_fast = 2'b00;
    #1 chk("R12 bypass released", {28'd0, irq_o, fast_o}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    bus_core = '0; local_src = '0; shared_src = '0;
    bypass_irq = '0; bypass_fast = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bank();
    t_local();
    t_shared();
    t_soft();
    t_fast();
    t_ack();
    t_bypass();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule